// File: doc/BRIEF.md
# Branch Trace Ring Buffer

The block keeps a short history of taken branches in a circular store. Each report from the retire side carries a source address, a destination address and a mispredict indication. A recorded report first advances a top-of-stack index, modulo the number of entries, and is then written at the new index. Software finds the entry k steps older than the newest one at index (top - k) modulo the depth.

A register port gives software read and write access to a control word, the top-of-stack index, and the source and destination record of every entry. The control word has two bits: a record-enable bit and a freeze-on-interrupt bit. When the freeze bit is set and the performance-monitor interrupt input is high, hardware clears the record-enable bit, so the history stays intact until software reads it. A static format input selects how a branch is encoded into the records. There are four formats: a packed 32-bit layout, two full 64-bit address layouts, and a layout with a mispredict flag.

Registers use the address `{region[1:0], index}`. Region 0 index 0 is the control word (bit 0 enable, bit 1 freeze), and region 0 index 1 is the top-of-stack index. Region 1 holds the source records and region 2 the destination records, selected by entry index. Every other address reads as zero.

Top module: `branch_trace_ring`

## Requirements
- R1: After reset the control word, the top-of-stack index and every source and destination record read as zero.
- R2: Each recorded branch increments the top-of-stack index by one modulo DEPTH. From DEPTH-1 the index wraps to 0.
- R3: A recorded branch is written at the newly incremented index. Older entries stay in place, so entry k steps older is found at (top - k) mod DEPTH.
- R4: While control bit 0 is clear, branch reports change neither the index nor any record.
- R5: When control bit 1 and bit 0 are both set and the interrupt input is high, bit 0 reads as clear from the next cycle on and bit 1 stays set. A report in that same cycle is recorded, and later reports are not.
- R6: While control bit 1 is clear, the interrupt input has no effect on the control word or on recording.
- R7: With format code 3, the source record holds the mispredict flag in bit 63 and source address bits 62:0 below it. The destination record holds the full destination address.
- R8: With format codes 1 and 2, the source and destination records hold the full 64-bit addresses and the mispredict indication is dropped.
- R9: With format code 0, the source record holds the destination address bits 31:0 in its upper half and the source address bits 31:0 in its lower half. Destination records then read as zero, and both recording and software writes leave them unchanged.
- R10: Software writes to the records, including writes of zero that clear them, read back as written. Read data appears one cycle after the read request and holds until the next read.
- R11: When a branch is recorded in the same cycle as a software write to a record or to the index, the branch takes effect and the software write is dropped.
- R12: After a freeze, recording resumes as soon as software sets control bit 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_format | input | 2 | Record format code (0 packed, 1 linear, 2 effective, 3 with flag) |
| br_valid | input | 1 | Taken-branch report strobe |
| br_from | input | 64 | Branch source address |
| br_to | input | 64 | Branch destination address |
| br_mispred | input | 1 | Branch was mispredicted |
| pmi | input | 1 | Performance-monitor interrupt |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | Register access is a write |
| reg_addr | input | IDX_W+2 (6) | Register address {region, index} |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, one cycle after the request |

## Verification
A branch report or register write presented in a cycle takes effect at that clock edge. A read request issued in the following cycle therefore sees the new index, the new record or the cleared enable bit. The data of each read is due on the edge after the request. The bench drives all inputs on the falling edge and queues the expected word for every read. A monitor pops that word on the next falling edge, once read data has been registered, so each comparison lands exactly one cycle after its request. Same-cycle cases are driven as one combined cycle, and their effect is checked through the following reads: branch plus interrupt, branch plus record write, and branch plus index write.

// File: rtl/btr_pkg.sv
// Package: shared types and constants of the branch trace ring.
// Assumes 64-bit records and a two-bit register region selector.
package btr_pkg;
    localparam int REC_W = 64;

    typedef enum logic [1:0] {
        FMT_PACKED32 = 2'd0,
        FMT_LINEAR   = 2'd1,
        FMT_EFFADDR  = 2'd2,
        FMT_EFFFLAG  = 2'd3
    } rec_fmt_e;

    typedef enum logic [1:0] {
        RGN_CTRL = 2'd0,
        RGN_SRC  = 2'd1,
        RGN_DST  = 2'd2,
        RGN_NONE = 2'd3
    } rgn_e;

    typedef struct packed {
        logic [REC_W-1:0] src_rec;
        logic [REC_W-1:0] dst_rec;
        logic             dst_we;
    } rec_pair_t;
endpackage

// File: rtl/btr_encode.sv
// Module: turns one branch report into the records of the selected format.
// Purely combinational; assumes the format input is static while branches flow.
module btr_encode
    import btr_pkg::*;
(
    input  logic [1:0]       fmt,
    input  logic [REC_W-1:0] from_addr,
    input  logic [REC_W-1:0] to_addr,
    input  logic             mispred,
    output rec_pair_t        recs
);
    // Purpose: pick the record layout for the current format code.
    always_comb begin
        recs.src_rec = from_addr;
        recs.dst_rec = to_addr;
        recs.dst_we  = 1'b1;
        case (rec_fmt_e'(fmt))
            FMT_PACKED32: begin
                recs.src_rec = {to_addr[31:0], from_addr[31:0]};
                recs.dst_rec = '0;
                recs.dst_we  = 1'b0;
            end
            FMT_EFFFLAG: begin
                recs.src_rec = {mispred, from_addr[REC_W-2:0]};
            end
            default: begin
                recs.src_rec = from_addr;
            end
        endcase
    end
endmodule

// File: rtl/btr_ctrl.sv
// Module: control word, freeze logic and top-of-stack index.
// Assumes DEPTH is a power of two so the index wraps by plain overflow.
module btr_ctrl #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic             pmi,
    input  logic             ctrl_we,
    input  logic [1:0]       ctrl_wdata,
    input  logic             tos_we,
    input  logic [IDX_W-1:0] tos_wdata,
    output logic             rec_on,
    output logic             frz_on,
    output logic [IDX_W-1:0] tos,
    output logic             rec_fire
);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic freeze_hit;

    assign rec_fire   = rec_on & br_valid;
    assign freeze_hit = pmi & frz_on & rec_on;

    // Purpose: hold the control bits; a freezing interrupt wins over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_on <= 1'b0;
            frz_on <= 1'b0;
        end else begin
            if (ctrl_we) begin
                rec_on <= ctrl_wdata[0];
                frz_on <= ctrl_wdata[1];
            end
            if (freeze_hit) begin
                rec_on <= 1'b0;
            end
        end
    end

    // Purpose: advance the index on a recorded branch, else take software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos <= '0;
        end else if (rec_fire) begin
            tos <= tos + IDX_ONE;
        end else if (tos_we) begin
            tos <= tos_wdata;
        end
    end
endmodule

// File: rtl/btr_store.sv
// Module: DEPTH entries of source and destination records.
// Recording has priority over software writes; reads are combinational.
module btr_store
    import btr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_we,
    input  logic [IDX_W-1:0] rec_idx,
    input  rec_pair_t        recs,
    input  logic             sw_src_we,
    input  logic             sw_dst_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [REC_W-1:0] sw_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REC_W-1:0] rd_src,
    output logic [REC_W-1:0] rd_dst
);
    logic [REC_W-1:0] src_arr [DEPTH];
    logic [REC_W-1:0] dst_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic [REC_W-1:0] src_q;
        logic [REC_W-1:0] dst_q;

        // Purpose: update this entry's source record.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q <= '0;
            end else if (rec_we && rec_idx == MY_IDX) begin
                src_q <= recs.src_rec;
            end else if (sw_src_we && sw_idx == MY_IDX) begin
                src_q <= sw_data;
            end
        end

        // Purpose: update this entry's destination record.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst_q <= '0;
            end else if (rec_we && recs.dst_we && rec_idx == MY_IDX) begin
                dst_q <= recs.dst_rec;
            end else if (sw_dst_we && sw_idx == MY_IDX) begin
                dst_q <= sw_data;
            end
        end

        assign src_arr[g] = src_q;
        assign dst_arr[g] = dst_q;
    end

    assign rd_src = src_arr[rd_idx];
    assign rd_dst = dst_arr[rd_idx];
endmodule

// File: rtl/branch_trace_ring.sv
// Module: top of the branch trace ring; decodes the register port,
// blocks software writes that collide with recording, registers read data.
// Assumes DEPTH is a power of two (4, 8 or 16 in use).
module branch_trace_ring
    import btr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int RA_W  = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rec_format,
    input  logic             br_valid,
    input  logic [REC_W-1:0] br_from,
    input  logic [REC_W-1:0] br_to,
    input  logic             br_mispred,
    input  logic             pmi,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [REC_W-1:0] reg_wdata,
    output logic [REC_W-1:0] reg_rdata
);
    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_TOS  = IDX_W'(1);

    rgn_e             rgn;
    logic [IDX_W-1:0] idx;
    logic             wr_req;
    logic             rd_req;
    logic             rec_on;
    logic             frz_on;
    logic [IDX_W-1:0] tos;
    logic             rec_fire;
    rec_pair_t        recs;
    logic [REC_W-1:0] rd_src;
    logic [REC_W-1:0] rd_dst;
    logic [REC_W-1:0] rd_val;
    logic             ctrl_we;
    logic             tos_we;
    logic             sw_src_we;
    logic             sw_dst_we;

    assign rgn    = rgn_e'(reg_addr[RA_W-1 -: 2]);
    assign idx    = reg_addr[IDX_W-1:0];
    assign wr_req = reg_en & reg_we;
    assign rd_req = reg_en & ~reg_we;

    assign ctrl_we   = wr_req && rgn == RGN_CTRL && idx == IDX_CTRL;
    assign tos_we    = wr_req && rgn == RGN_CTRL && idx == IDX_TOS && !rec_fire;
    assign sw_src_we = wr_req && rgn == RGN_SRC && !rec_fire;
    assign sw_dst_we = wr_req && rgn == RGN_DST && !rec_fire
                       && rec_fmt_e'(rec_format) != FMT_PACKED32;

    btr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_valid   (br_valid),
        .pmi        (pmi),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (reg_wdata[1:0]),
        .tos_we     (tos_we),
        .tos_wdata  (reg_wdata[IDX_W-1:0]),
        .rec_on     (rec_on),
        .frz_on     (frz_on),
        .tos        (tos),
        .rec_fire   (rec_fire)
    );

    btr_encode u_enc (
        .fmt       (rec_format),
        .from_addr (br_from),
        .to_addr   (br_to),
        .mispred   (br_mispred),
        .recs      (recs)
    );

    btr_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_we    (rec_fire),
        .rec_idx   (tos + IDX_W'(1)),
        .recs      (recs),
        .sw_src_we (sw_src_we),
        .sw_dst_we (sw_dst_we),
        .sw_idx    (idx),
        .sw_data   (reg_wdata),
        .rd_idx    (idx),
        .rd_src    (rd_src),
        .rd_dst    (rd_dst)
    );

    // Purpose: select the addressed register for a read.
    always_comb begin
        rd_val = '0;
        case (rgn)
            RGN_CTRL: begin
                if (idx == IDX_CTRL) rd_val = {{(REC_W-2){1'b0}}, frz_on, rec_on};
                else if (idx == IDX_TOS) rd_val = REC_W'(tos);
            end
            RGN_SRC: rd_val = rd_src;
            RGN_DST: begin
                if (rec_fmt_e'(rec_format) != FMT_PACKED32) rd_val = rd_dst;
            end
            default: rd_val = '0;
        endcase
    end

    // Purpose: register read data one cycle after the request; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (rd_req) begin
            reg_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/branch_trace_ring_chk.sv
// Module: assertion checker for the branch trace ring, bound to the top.
module branch_trace_ring_chk #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int RA_W  = IDX_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       rec_format,
    input logic             br_valid,
    input logic             pmi,
    input logic             reg_en,
    input logic             reg_we,
    input logic [RA_W-1:0]  reg_addr,
    input logic [63:0]      reg_rdata,
    input logic             rec_on,
    input logic             frz_on,
    input logic [IDX_W-1:0] tos
);
    logic tos_wr;
    assign tos_wr = reg_en && reg_we && reg_addr == {2'b00, IDX_W'(1)};

    assert_tos_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_on && br_valid) |=> tos == $past(tos) + IDX_W'(1));

    assert_no_rec_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_on && !tos_wr) |=> $stable(tos));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pmi && frz_on && rec_on) |=> !rec_on);

    assert_no_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pmi && !frz_on && rec_on && !(reg_en && reg_we)) |=> rec_on);

    assert_dst_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr[RA_W-1 -: 2] == 2'd2 && rec_format == 2'd0)
        |=> reg_rdata == 64'd0);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> $stable(reg_rdata));
endmodule

bind branch_trace_ring branch_trace_ring_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RA_W(RA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_format (rec_format),
    .br_valid   (br_valid),
    .pmi        (pmi),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .rec_on     (rec_on),
    .frz_on     (frz_on),
    .tos        (tos)
);

// File: tb/branch_trace_ring_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected read words, popped one cycle after each read.
module branch_trace_ring_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rec_format = 2'd1;
    logic        br_valid = 1'b0;
    logic [63:0] br_from = '0;
    logic [63:0] br_to = '0;
    logic        br_mispred = 1'b0;
    logic        pmi = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit issued_q = 0;
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    branch_trace_ring u_dut (
        .clk(clk), .rst_n(rst_n), .rec_format(rec_format),
        .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .br_mispred(br_mispred), .pmi(pmi), .reg_en(reg_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    localparam logic [5:0] A_CTRL = 6'h00;
    localparam logic [5:0] A_TOS  = 6'h01;
    function automatic logic [5:0] a_src(int i); return {2'b01, 4'(i)}; endfunction
    function automatic logic [5:0] a_dst(int i); return {2'b10, 4'(i)}; endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic bv, logic [63:0] f, logic [63:0] t, logic mp, logic p,
                         logic re, logic we, logic [5:0] a, logic [63:0] d);
        @(negedge clk);
        br_valid = bv; br_from = f; br_to = t; br_mispred = mp; pmi = p;
        reg_en = re; reg_we = we; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle(); drive(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic wr(logic [5:0] a, logic [63:0] d); drive(0, 0, 0, 0, 0, 1, 1, a, d); endtask
    task automatic br(logic [63:0] f, logic [63:0] t, logic mp); drive(1, f, t, mp, 0, 0, 0, 0, 0); endtask
    task automatic rd(logic [5:0] a, logic [63:0] exp, string tag);
        drive(0, 0, 0, 0, 0, 1, 0, a, 0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: note each read request at the edge that services it.
    always @(posedge clk) issued_q <= rst_n && reg_en && !reg_we;

    // Monitor: compare read data one falling edge after the servicing edge.
    always @(negedge clk) begin
        if (issued_q) begin
            if (exp_q.size() == 0) begin
                check(0, "scoreboard-empty", reg_rdata, 0);
            end else begin
                logic [63:0] e;
                string s;
                e = exp_q.pop_front();
                s = tag_q.pop_front();
                check(reg_rdata === e, s, reg_rdata, e);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] af, at, bf, bt, cf, ct, df, dt, ef, et;
        af = 64'h0000_0000_0040_1000; at = 64'h0000_0000_0040_2000;
        bf = 64'h0000_0000_0040_1100; bt = 64'h0000_0000_0040_3000;
        cf = 64'h0000_0000_0040_1200; ct = 64'h0000_0000_0040_4000;
        df = 64'h0000_7fff_1234_5678; dt = 64'h0000_7fff_0000_0100;
        ef = 64'hffff_8000_0000_0010; et = 64'hffff_8000_0000_0020;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, 64'd0, "R1 ctrl");
        rd(A_TOS, 64'd0, "R1 tos");
        rd(a_src(5), 64'd0, "R1 src5");
        rd(a_dst(15), 64'd0, "R1 dst15");

        // R2 R3 R8: three branches, linear format
        wr(A_CTRL, 64'd3);
        br(af, at, 0);
        br(bf, bt, 1);
        br(cf, ct, 0);
        rd(A_TOS, 64'd3, "R2 tos after 3");
        rd(a_src(1), af, "R3 oldest src at 1");
        rd(a_src(2), bf, "R8 mispred dropped");
        rd(a_dst(3), ct, "R3 newest dst at 3");

        // R7: flagged format
        idle(); rec_format = 2'd3;
        br(df, dt, 1);
        br(ef, et, 0);
        rd(a_src(4), 64'h8000_7fff_1234_5678, "R7 flag set");
        rd(a_src(5), 64'h7fff_8000_0000_0010, "R7 flag clear");
        rd(a_dst(5), et, "R7 dst full");
        rd(A_TOS, 64'd5, "R7 tos");
        idle(); idle();
        check(reg_rdata === 64'd5, "R10 rdata hold", reg_rdata, 64'd5);

        // R4: disabled
        wr(A_CTRL, 64'd0);
        br(64'h1111, 64'h2222, 0);
        rd(A_TOS, 64'd5, "R4 tos unchanged");
        rd(a_src(6), 64'd0, "R4 src6 untouched");

        // R6: interrupt without freeze bit
        wr(A_CTRL, 64'd1);
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0);
        br(64'h0000_0000_00aa_0000, 64'h1, 0);
        rd(A_CTRL, 64'd1, "R6 ctrl kept");
        rd(A_TOS, 64'd6, "R6 still recording");

        // R5: freeze with a same-cycle branch, then one ignored
        wr(A_CTRL, 64'd3);
        drive(1, 64'h0000_0000_00bb_0000, 64'h2, 1, 1, 0, 0, 0, 0);
        br(64'h0000_0000_00ee_0000, 64'h3, 0);
        rd(A_CTRL, 64'd2, "R5 enable cleared");
        rd(A_TOS, 64'd7, "R5 tos");
        rd(a_src(7), 64'h8000_0000_00bb_0000, "R5 same-cycle recorded");
        rd(a_src(8), 64'd0, "R5 later ignored");

        // R12: resume
        wr(A_CTRL, 64'd3);
        br(64'h0000_0000_00cc_0000, 64'h4, 0);
        rd(A_TOS, 64'd8, "R12 tos");
        rd(a_src(8), 64'h0000_0000_00cc_0000, "R12 recorded");

        // R2 wrap
        wr(A_TOS, 64'd15);
        br(64'h0000_0000_00dd_0000, 64'h5, 0);
        rd(A_TOS, 64'd0, "R2 wrap tos");
        rd(a_src(0), 64'h0000_0000_00dd_0000, "R2 wrap entry0");

        // R11: collisions
        drive(1, 64'h0000_0000_0011_0000, 64'h6, 0, 0, 1, 1, a_src(1), 64'hdead_beef);
        drive(1, 64'h0000_0000_0022_0000, 64'h7, 0, 0, 1, 1, A_TOS, 64'd9);
        rd(a_src(1), 64'h0000_0000_0011_0000, "R11 entry write dropped");
        rd(A_TOS, 64'd2, "R11 tos write dropped");

        // R9: packed format
        idle(); rec_format = 2'd0;
        br(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1);
        rd(a_src(3), 64'h7777_8888_3333_4444, "R9 packed src");
        rd(a_dst(3), 64'd0, "R9 dst reads zero");
        wr(a_dst(3), 64'hffff_ffff_ffff_ffff);
        idle(); rec_format = 2'd1;
        rd(a_dst(3), ct, "R9 dst unchanged");

        // R10: software clear and write
        wr(a_src(3), 64'd0);
        wr(a_dst(3), 64'd0);
        rd(a_src(3), 64'd0, "R10 src cleared");
        rd(a_dst(3), 64'd0, "R10 dst cleared");
        wr(a_src(9), 64'h0123_4567_89ab_cdef);
        rd(a_src(9), 64'h0123_4567_89ab_cdef, "R10 write readback");

        idle(); idle(); idle();
        check(exp_q.size() == 0, "scoreboard-drain", 64'(exp_q.size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule